// File: doc/BRIEF.md
# Tagged Section Parser

This block scans a byte stream holding a configuration container and finds one section in it. The container opens with a fixed 13-byte signature. A series of tagged sections follows. Each section carries a one-byte letter tag, a big-endian length, and that many payload bytes. The caller picks a tag letter and pulses `start`. The parser then takes bytes over a valid/ready handshake and counts each byte it accepts. It reports whether the section was found and, if so, the byte position where its payload begins and the payload length.

The parser never reads payload contents. It skips the payload of each section that does not match and moves on to the next tag. The scan ends in one of five ways: a match, a bad signature, a bad tag letter, a short length that is too large, or the end of the container. The end of the container is marked by `inLast` on its final byte. The results stay on the outputs until the next `start`.

Top module: `sec_parser`

## Requirements
- R1: The first 13 accepted bytes must equal 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01. If any byte differs, or if the container ends before the 13th byte, the scan stops with `done`=1, `headerBad`=1 and `found`=0.
- R2: Byte positions count from 0, which is the first byte accepted after `start`. Each section is a tag byte followed by its length field. The reported `startOffset` is the position of the byte right after the length field.
- R3: Tag 0x65 ('e') has a 4-byte big-endian length. Every other tag has a 2-byte big-endian length. Lengths above 255 are accepted for tag 0x65.
- R4: A tag byte outside 0x61..0x65 stops the scan with `done`=1, `formatBad`=1 and `found`=0.
- R5: A 2-byte length greater than 255 stops the scan with `done`=1, `formatBad`=1 and `found`=0. A length of exactly 255 is valid.
- R6: When a section's tag equals the requested tag, the parser sets `found`=1 and `done`=1. It places the payload start in `startOffset` and the length in `sectionLen`, all in the cycle after the last length byte is accepted. From then on `inReady` stays 0.
- R7: The payload of a section that does not match is consumed and discarded, and `inReady` stays 1 throughout. A zero-length section goes straight on to the next tag.
- R8: If the byte marked by `inLast` is accepted and no match has been made, the scan stops with `done`=1, `found`=0, both error flags 0, and `startOffset` and `sectionLen` both 0.
- R9: `start` clears every result and restarts the scan. The results hold steady until the next `start`. Bytes offered while `done` is 1 are not accepted and change nothing.
- R10: After reset, `inReady`, `done`, `found`, `headerBad` and `formatBad` are all 0.
- R11: A byte is counted only on a cycle where both `inValid` and `inReady` are 1. Idle cycles between bytes do not change the reported offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a new scan |
| reqTag | input | 8 | Tag letter to search for, sampled on `start` |
| inValid | input | 1 | Stream byte valid |
| inByte | input | 8 | Stream byte |
| inLast | input | 1 | Marks the final byte of the container |
| inReady | output | 1 | Parser accepts a byte this cycle |
| done | output | 1 | Scan finished |
| found | output | 1 | Requested section located |
| headerBad | output | 1 | Signature mismatch |
| formatBad | output | 1 | Bad tag letter or oversized short length |
| startOffset | output | OFF_W | Position of the first payload byte of the match |
| sectionLen | output | LEN_W | Payload length of the match |

## Verification
The assertions assume that `start` is a single-cycle pulse. They also assume that `reqTag` is steady while `start` is high, and that `inByte` and `inLast` are meaningful only when `inValid` is 1. The stimulus keeps to these assumptions. It changes every input on the falling clock edge. It raises `start` for exactly one cycle. It drops `inValid` once each byte has been taken, and it inserts idle cycles on some runs. While `done` is high it offers bytes only to confirm that they are refused. It never pulses `start` in the middle of a byte.

// File: rtl/secp_pkg.sv
package secp_pkg;
  localparam int PRE_LEN = 13;
  localparam int IDX_W = $clog2(PRE_LEN);
  localparam logic [7:0] TAG_LO = 8'h61;
  localparam logic [7:0] TAG_HI = 8'h65;
  localparam logic [7:0] TAG_LONG = 8'h65;
  localparam int SHORT_MAX = 255;

  // signature byte at a given position
  function automatic logic [7:0] preByte(input logic [IDX_W-1:0] i);
    logic [7:0] b;
    case (i)
      4'd0, 4'd10, 4'd11: b = 8'h00;
      4'd1: b = 8'h09;
      4'd2, 4'd4, 4'd6, 4'd8: b = 8'h0F;
      4'd3, 4'd5, 4'd7, 4'd9: b = 8'hF0;
      4'd12: b = 8'h01;
      default: b = 8'hXX;
    endcase
    return b;
  endfunction

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_TAG, ST_LEN, ST_SKIP, ST_FIN
  } state_t;

  typedef struct packed {
    logic clrAll;
    logic accept;
    logic incIdx;
    logic latchTag;
    logic shiftLen;
    logic loadSkip;
    logic decSkip;
    logic setFound;
    logic setDone;
    logic setHdrBad;
    logic setFmtBad;
  } strb_t;

  typedef struct packed {
    logic preOk;
    logic preFinal;
    logic tagValid;
    logic lenFinal;
    logic lenTooBig;
    logic tagMatch;
    logic lenZero;
    logic skipFinal;
  } stat_t;
endpackage

// File: rtl/secp_ctrl.sv
module secp_ctrl
  import secp_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  input  logic  inValid,
  input  logic  inLast,
  input  stat_t st,
  output strb_t strb,
  output logic  inReady
);
  state_t state, nxt;
  logic acc;

  assign inReady = (state == ST_PRE) || (state == ST_TAG) ||
                   (state == ST_LEN) || (state == ST_SKIP);
  assign acc = inValid && inReady;

  always_comb begin
    strb = '0;
    nxt = state;
    if (start) begin
      strb.clrAll = 1'b1;
      nxt = ST_PRE;
    end else if (acc) begin
      strb.accept = 1'b1;
      case (state)
        ST_PRE: begin
          if (!st.preOk || (inLast && !st.preFinal)) begin
            strb.setHdrBad = 1'b1;
            strb.setDone = 1'b1;
            nxt = ST_FIN;
          end else if (st.preFinal) begin
            if (inLast) begin
              strb.setDone = 1'b1;
              nxt = ST_FIN;
            end else begin
              nxt = ST_TAG;
            end
          end else begin
            strb.incIdx = 1'b1;
          end
        end
        ST_TAG: begin
          if (!st.tagValid) begin
            strb.setFmtBad = 1'b1;
            strb.setDone = 1'b1;
            nxt = ST_FIN;
          end else if (inLast) begin
            strb.setDone = 1'b1;
            nxt = ST_FIN;
          end else begin
            strb.latchTag = 1'b1;
            nxt = ST_LEN;
          end
        end
        ST_LEN: begin
          strb.shiftLen = 1'b1;
          strb.incIdx = 1'b1;
          if (st.lenFinal) begin
            if (st.lenTooBig) begin
              strb.setFmtBad = 1'b1;
              strb.setDone = 1'b1;
              nxt = ST_FIN;
            end else if (st.tagMatch) begin
              strb.setFound = 1'b1;
              strb.setDone = 1'b1;
              nxt = ST_FIN;
            end else if (inLast) begin
              strb.setDone = 1'b1;
              nxt = ST_FIN;
            end else if (st.lenZero) begin
              nxt = ST_TAG;
            end else begin
              strb.loadSkip = 1'b1;
              nxt = ST_SKIP;
            end
          end else if (inLast) begin
            strb.setDone = 1'b1;
            nxt = ST_FIN;
          end
        end
        ST_SKIP: begin
          strb.decSkip = 1'b1;
          if (inLast) begin
            strb.setDone = 1'b1;
            nxt = ST_FIN;
          end else if (st.skipFinal) begin
            nxt = ST_TAG;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end
endmodule

// File: rtl/secp_dp.sv
module secp_dp
  import secp_pkg::*;
#(
  parameter int OFF_W = 32,
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strb_t            strb,
  input  logic [7:0]       inByte,
  input  logic [7:0]       reqTag,
  output stat_t            st,
  output logic [OFF_W-1:0] startOffset,
  output logic [LEN_W-1:0] sectionLen,
  output logic             found,
  output logic             done,
  output logic             headerBad,
  output logic             formatBad
);
  localparam logic [IDX_W-1:0] PRE_LAST = IDX_W'(PRE_LEN - 1);
  localparam logic [IDX_W-1:0] LONG_LAST = IDX_W'(3);
  localparam logic [IDX_W-1:0] SHORT_LAST = IDX_W'(1);

  logic [OFF_W-1:0] offset;
  logic [IDX_W-1:0] idx;
  logic [7:0]       curTag, wantTag;
  logic [LEN_W-1:0] lenAcc, lenNext, skipCnt;
  logic             isLong;

  assign isLong  = (curTag == TAG_LONG);
  assign lenNext = {lenAcc[LEN_W-9:0], inByte};

  always_comb begin
    st.preOk     = (inByte == preByte(idx));
    st.preFinal  = (idx == PRE_LAST);
    st.tagValid  = (inByte >= TAG_LO) && (inByte <= TAG_HI);
    st.lenFinal  = (idx == (isLong ? LONG_LAST : SHORT_LAST));
    st.lenTooBig = !isLong && (lenNext > LEN_W'(SHORT_MAX));
    st.tagMatch  = (curTag == wantTag);
    st.lenZero   = (lenNext == '0);
    st.skipFinal = (skipCnt == LEN_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offset <= '0;
      idx <= '0;
      curTag <= '0;
      wantTag <= '0;
      lenAcc <= '0;
      skipCnt <= '0;
    end else if (strb.clrAll) begin
      offset <= '0;
      idx <= '0;
      curTag <= '0;
      wantTag <= reqTag;
      lenAcc <= '0;
      skipCnt <= '0;
    end else begin
      if (strb.accept) offset <= offset + OFF_W'(1);
      if (strb.latchTag) begin
        curTag <= inByte;
        lenAcc <= '0;
        idx <= '0;
      end else if (strb.incIdx) begin
        idx <= idx + IDX_W'(1);
      end
      if (strb.shiftLen) lenAcc <= lenNext;
      if (strb.loadSkip) skipCnt <= lenNext;
      else if (strb.decSkip) skipCnt <= skipCnt - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      found <= 1'b0;
      done <= 1'b0;
      headerBad <= 1'b0;
      formatBad <= 1'b0;
      startOffset <= '0;
      sectionLen <= '0;
    end else if (strb.clrAll) begin
      found <= 1'b0;
      done <= 1'b0;
      headerBad <= 1'b0;
      formatBad <= 1'b0;
      startOffset <= '0;
      sectionLen <= '0;
    end else begin
      if (strb.setDone) done <= 1'b1;
      if (strb.setHdrBad) headerBad <= 1'b1;
      if (strb.setFmtBad) formatBad <= 1'b1;
      if (strb.setFound) begin
        found <= 1'b1;
        startOffset <= offset + OFF_W'(1);
        sectionLen <= lenNext;
      end
    end
  end
endmodule

// File: rtl/sec_parser.sv
module sec_parser
  import secp_pkg::*;
#(
  parameter int OFF_W = 32,
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [7:0]       reqTag,
  input  logic             inValid,
  input  logic [7:0]       inByte,
  input  logic             inLast,
  output logic             inReady,
  output logic             done,
  output logic             found,
  output logic             headerBad,
  output logic             formatBad,
  output logic [OFF_W-1:0] startOffset,
  output logic [LEN_W-1:0] sectionLen
);
  strb_t strb;
  stat_t st;

  secp_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid),
    .inLast(inLast), .st(st), .strb(strb), .inReady(inReady)
  );

  secp_dp #(.OFF_W(OFF_W), .LEN_W(LEN_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inByte(inByte), .reqTag(reqTag),
    .st(st), .startOffset(startOffset), .sectionLen(sectionLen),
    .found(found), .done(done), .headerBad(headerBad), .formatBad(formatBad)
  );
endmodule

// File: rtl/secp_checker.sv
module secp_checker #(
  parameter int OFF_W = 32,
  parameter int LEN_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             inReady,
  input logic             done,
  input logic             found,
  input logic             headerBad,
  input logic             formatBad,
  input logic [OFF_W-1:0] startOffset,
  input logic [LEN_W-1:0] sectionLen
);
  logic running;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      running <= 1'b0;
    else if (start) running <= 1'b1;
    else if (done)  running <= 1'b0;
  end

  assert_found_has_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    found |-> done);
  assert_done_blocks_input_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !inReady);
  assert_ready_in_scan_R7: assert property (@(posedge clk) disable iff (!rstN)
    (running && !done && !start) |-> inReady);
  assert_hold_results_R9: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && $stable(found) && $stable(startOffset) &&
                          $stable(sectionLen) && $stable(headerBad) && $stable(formatBad)));
  assert_clear_on_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (!done && !found && !headerBad && !formatBad && startOffset == '0));
  assert_header_excl_R1: assert property (@(posedge clk) disable iff (!rstN)
    headerBad |-> (done && !found && !formatBad));
  assert_format_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    formatBad |-> (done && !found));
  assert_notfound_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !found) |-> (startOffset == '0 && sectionLen == '0));
endmodule

bind sec_parser secp_checker #(.OFF_W(OFF_W), .LEN_W(LEN_W)) i_chk (.*);

// File: tb/test_sec_parser.sv
module test_sec_parser;
  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, inValid = 1'b0, inLast = 1'b0;
  logic [7:0] reqTag = 8'h00, inByte = 8'h00;
  logic inReady, done, found, headerBad, formatBad;
  logic [31:0] startOffset, sectionLen;
  int nChk = 0, nBad = 0;
  logic [7:0] sBuf [0:63];
  int sLen = 0;

  localparam logic [7:0] TBL_REQ [6] = '{8'h61, 8'h62, 8'h63, 8'h64, 8'h65, 8'h66};
  localparam int TBL_FND [6] = '{1, 1, 1, 1, 1, 0};
  localparam int TBL_OFF [6] = '{16, 22, 25, 30, 36, 0};
  localparam int TBL_LEN [6] = '{3, 0, 2, 1, 5, 0};

  always #10 clk = ~clk;

  sec_parser i_sec_parser (
    .clk(clk), .rstN(rstN), .start(start), .reqTag(reqTag), .inValid(inValid),
    .inByte(inByte), .inLast(inLast), .inReady(inReady), .done(done),
    .found(found), .headerBad(headerBad), .formatBad(formatBad),
    .startOffset(startOffset), .sectionLen(sectionLen)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    sBuf[sLen] = b;
    sLen++;
  endtask

  task automatic putPre();
    sLen = 0;
    put(8'h00); put(8'h09);
    for (int i = 0; i < 4; i++) begin put(8'h0F); put(8'hF0); end
    put(8'h00); put(8'h00); put(8'h01);
  endtask

  task automatic buildStd();
    putPre();
    put(8'h61); put(8'h00); put(8'h03); put(8'h11); put(8'h22); put(8'h33);
    put(8'h62); put(8'h00); put(8'h00);
    put(8'h63); put(8'h00); put(8'h02); put(8'h44); put(8'h55);
    put(8'h64); put(8'h00); put(8'h01); put(8'h66);
    put(8'h65); put(8'h00); put(8'h00); put(8'h00); put(8'h05);
    for (int i = 0; i < 5; i++) put(8'h70 + 8'(i));
  endtask

  task automatic runScan(input logic [7:0] req, input bit gaps);
    @(negedge clk); reqTag = req; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < sLen; k++) begin
      if (!inReady) break;
      if (gaps && (k % 3 == 1)) @(negedge clk);
      inValid = 1'b1; inByte = sBuf[k]; inLast = (k == sLen - 1);
      @(negedge clk);
      inValid = 1'b0; inLast = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 ready", inReady, 0);
    chk("R10 done", done, 0);
    chk("R10 found", found, 0);
    chk("R10 errors", headerBad | formatBad, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 ready after release", inReady, 0);

    // table walk: R2 R3 R6 R7 R8 R11 (gaps on odd rows)
    buildStd();
    for (int i = 0; i < 6; i++) begin
      runScan(TBL_REQ[i], i[0]);
      chk("R6 done", done, 1);
      chk("R6 found", found, TBL_FND[i]);
      chk("R2 offset", startOffset, TBL_OFF[i]);
      chk("R3 length", sectionLen, TBL_LEN[i]);
      chk("R6 ready low", inReady, 0);
      chk("R8 no errors", headerBad | formatBad, 0);
    end

    // R9 hold and ignore while done
    buildStd();
    runScan(8'h63, 1'b0);
    @(negedge clk); inValid = 1'b1; inByte = 8'h61; inLast = 1'b1;
    repeat (4) @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
    chk("R9 held found", found, 1);
    chk("R9 held offset", startOffset, 25);
    chk("R9 held len", sectionLen, 2);
    chk("R9 ready stays low", inReady, 0);
    @(negedge clk); reqTag = 8'h61; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R9 start clears done", done, 0);
    chk("R9 start clears found", found, 0);
    chk("R9 start clears offset", startOffset, 0);
    chk("R9 scan ready", inReady, 1);

    // R1 signature mismatch
    buildStd();
    sBuf[5] = 8'hF1;
    runScan(8'h61, 1'b0);
    chk("R1 headerBad", headerBad, 1);
    chk("R1 found", found, 0);
    chk("R1 done", done, 1);
    // R1 container ends inside signature
    putPre(); sLen = 7;
    runScan(8'h61, 1'b0);
    chk("R1 short header", headerBad, 1);
    // signature only, full: not found, no error
    putPre();
    runScan(8'h61, 1'b0);
    chk("R8 sig only done", done, 1);
    chk("R8 sig only headerBad", headerBad, 0);

    // R4 bad tag letters above and below range
    putPre(); put(8'h7A); put(8'h00); put(8'h01); put(8'h00);
    runScan(8'h61, 1'b0);
    chk("R4 formatBad high", formatBad, 1);
    chk("R4 found", found, 0);
    putPre(); put(8'h61); put(8'h00); put(8'h00); put(8'h60); put(8'h00);
    runScan(8'h61, 1'b0);
    chk("R4 zero-length match found", found, 1);
    chk("R4 zero-length offset", startOffset, 16);
    runScan(8'h62, 1'b0);
    chk("R4 formatBad low", formatBad, 1);

    // R5 oversize and boundary
    putPre(); put(8'h62); put(8'h01); put(8'h00); put(8'h00);
    runScan(8'h63, 1'b0);
    chk("R5 oversize formatBad", formatBad, 1);
    chk("R5 oversize found", found, 0);
    putPre(); put(8'h62); put(8'h00); put(8'hFF); put(8'h00);
    runScan(8'h62, 1'b0);
    chk("R5 255 found", found, 1);
    chk("R5 255 len", sectionLen, 255);
    chk("R5 255 offset", startOffset, 16);

    // R3 long length beyond 255
    putPre(); put(8'h65); put(8'h00); put(8'h00); put(8'h03); put(8'h00); put(8'h00);
    runScan(8'h65, 1'b1);
    chk("R3 long found", found, 1);
    chk("R3 long len", sectionLen, 768);
    chk("R3 long offset", startOffset, 18);
    chk("R3 long formatBad", formatBad, 0);

    // R8 truncated inside payload
    putPre(); put(8'h61); put(8'h00); put(8'h05); put(8'h01); put(8'h02);
    runScan(8'h62, 1'b1);
    chk("R8 trunc done", done, 1);
    chk("R8 trunc found", found, 0);
    chk("R8 trunc errors", headerBad | formatBad, 0);
    chk("R7 trunc len zero", sectionLen, 0);

    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule